// File: doc/BRIEF.md
# Power Mode and Bus Clock Divider Controller

This block decides which power mode a small CPU subsystem is in and how fast its bus masters run. From the full-rate system clock it makes two clock enables. One goes to the bus masters and is a single-cycle pulse repeating every 1, 2, 4, 8, 16 or 32 system cycles. The other goes to the peripherals and stays at full rate. Software picks the bus-master rate through a 3-bit select field. A new value is adopted only when the current bus cycle ends, so a bus transfer never sees its clock change partway through.

A sleep strobe, raised when the CPU executes its sleep instruction, is decoded from three control bits (standby, low-speed and watchdog clock-source) into either light sleep or software standby. In light sleep the bus masters are halted and the peripherals keep running, and any interrupt wakes the block. In software standby both enables are stopped, and only an external interrupt wakes the block. On wake-up the block returns to the speed mode that was applied before it went to sleep. A low level on the reset pin, a watchdog overflow, or the synchronous reset input forces the reset state from any mode.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While `rst` is high, `rst_pin_n` is low or `wdt_ovf` is high, the next cycle shows `mode` = 0 (reset), `bm_clk_en` = 0 and `periph_clk_en` = 0. This holds from any mode, sleep and standby included.
- R2: In the first cycle with no reset cause, the controller moves to `mode` = 1 (high speed) with the applied divisor cleared, whatever `clk_sel` holds. `bm_clk_en` is 0 in the cycle after that edge and 1 in every cycle after the next one.
- R3: `clk_sel` encodes the divisor as 0 → /1, 1 → /2, 2 → /4, 3 → /8, 4 → /16, 5 → /32. The values 6 and 7 are treated as /32.
- R4: A change of `clk_sel` has no effect until a cycle with `bus_end` high in mode 1 or 2. At that edge the new divisor is applied, and `mode` becomes 1 if the divisor is /1 and 2 (medium speed) otherwise.
- R5: After the edge that applies a divisor d (or wakes the block, or leaves reset), `bm_clk_en` is 0 in the following cycle. It is then high for exactly one cycle after every d-th edge, so no shortened first period occurs.
- R6: `periph_clk_en` is 1 in modes 1, 2 and 3.
- R7: `sleep_req` in mode 1 or 2 with `stby_bit` = 0 and `lowspd_bit` = 0 gives `mode` = 3 (sleep) at the next cycle, with `bm_clk_en` held at 0.
- R8: `sleep_req` in mode 1 or 2 with `stby_bit` = 1, `lowspd_bit` = 0 and `wdt_src_bit` = 0 gives `mode` = 4 (standby), with `bm_clk_en` and `periph_clk_en` both held at 0.
- R9: `sleep_req` with `lowspd_bit` = 1, or with `stby_bit` = 1 and `wdt_src_bit` = 1, is ignored and the mode does not change.
- R10: In mode 3, `irq` or `ext_irq` returns the block to the speed mode of the applied divisor (1 or 2). In mode 4 only `ext_irq` does so, and `irq` leaves the block in mode 4.
- R11: When `sleep_req` enters sleep or standby in the same cycle as `bus_end`, the sleep wins and the new `clk_sel` value is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | Reset pin, active low, sampled synchronously |
| wdt_ovf | input | 1 | Watchdog overflow, forces reset |
| clk_sel | input | 3 | Bus-master clock select field |
| stby_bit | input | 1 | Standby control bit |
| lowspd_bit | input | 1 | Low-speed control bit |
| wdt_src_bit | input | 1 | Watchdog clock-source bit |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | Current bus cycle ends this cycle |
| irq | input | 1 | Any interrupt request |
| ext_irq | input | 1 | External interrupt request |
| mode | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 standby |
| bm_clk_en | output | 1 | Bus-master clock enable pulse |
| periph_clk_en | output | 1 | Peripheral clock enable |

## Verification
Every output is a register loaded from the next-state logic. So `mode` and `periph_clk_en` take their new values in the cycle right after the edge that samples a stimulus. `bm_clk_en` is 0 in that cycle and pulses first in the cycle after the d-th edge that follows. The bench drives inputs and samples outputs on the falling edge, and indexes each cycle from the applying edge. At every index k it compares `bm_clk_en` against (k mod d = 0, k ≥ 1), sweeping all eight select values. It covers wake-up, reset release and the cases where a stimulus is ignored, checking each one cycle after the edge concerned.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [2:0] {
    MD_RESET   = 3'd0,
    MD_HIGH    = 3'd1,
    MD_MEDIUM  = 3'd2,
    MD_SLEEP   = 3'd3,
    MD_STANDBY = 3'd4
  } pcc_mode_e;

  function automatic logic mode_running(pcc_mode_e m);
    return (m == MD_HIGH) || (m == MD_MEDIUM);
  endfunction

endpackage

// File: rtl/pcc_sleep_decode.sv
module pcc_sleep_decode (
  input  logic sleep_req,
  input  logic stby_bit,
  input  logic lowspd_bit,
  input  logic wdt_src_bit,
  output logic go_sleep,
  output logic go_standby
);

  // Light sleep: standby off, low-speed off.
  // Software standby: standby on, low-speed off, watchdog on main clock source.
  always_comb begin
    go_sleep   = sleep_req && !stby_bit && !lowspd_bit;
    go_standby = sleep_req &&  stby_bit && !lowspd_bit && !wdt_src_bit;
  end

endmodule

// File: rtl/pcc_clk_div.sv
module pcc_clk_div #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             bm_en_q
);

  localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   div_full;
  logic [CNT_W-1:0] limit;

  always_comb begin
    div_full = {{CNT_W{1'b0}}, 1'b1} << sel;
    limit    = CNT_W'(div_full - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q   <= '0;
      bm_en_q <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q   <= '0;
      bm_en_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      bm_en_q <= 1'b0;
    end
  end

  // R5: with any real division, two pulses never sit in adjacent cycles
  a_r5_no_adjacent_pulse: assert property (@(posedge clk) disable iff (rst)
    (bm_en_q && sel != '0) |=> !bm_en_q);

  // R5: the phase counter never runs past the current terminal count
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (!restart && run && cnt_q <= limit) |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin_n,
  input  logic             wdt_ovf,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             bus_end,
  input  logic             go_sleep,
  input  logic             go_standby,
  input  logic             irq,
  input  logic             ext_irq,
  output pcc_mode_e        mode_q,
  output pcc_mode_e        mode_d,
  output logic [SEL_W-1:0] sel_q,
  output logic             restart
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_SHIFT);

  logic             any_rst;
  logic             apply;
  logic [SEL_W-1:0] sel_norm;
  logic [SEL_W-1:0] sel_d;
  pcc_mode_e        speed_mode;

  always_comb begin
    any_rst    = rst || !rst_pin_n || wdt_ovf;
    sel_norm   = (clk_sel > SEL_MAX) ? SEL_MAX : clk_sel;
    speed_mode = (sel_q == '0) ? MD_HIGH : MD_MEDIUM;
  end

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    apply  = 1'b0;
    if (any_rst) begin
      mode_d = MD_RESET;
      sel_d  = '0;
    end else begin
      unique case (mode_q)
        MD_RESET: begin
          mode_d = MD_HIGH;
          sel_d  = '0;
        end
        MD_HIGH, MD_MEDIUM: begin
          if (go_sleep) begin
            mode_d = MD_SLEEP;
          end else if (go_standby) begin
            mode_d = MD_STANDBY;
          end else if (bus_end) begin
            apply  = 1'b1;
            sel_d  = sel_norm;
            mode_d = (sel_norm == '0) ? MD_HIGH : MD_MEDIUM;
          end
        end
        MD_SLEEP: begin
          if (irq || ext_irq) mode_d = speed_mode;
        end
        MD_STANDBY: begin
          if (ext_irq) mode_d = speed_mode;
        end
        default: begin
          mode_d = MD_RESET;
          sel_d  = '0;
        end
      endcase
    end
  end

  assign restart = apply || (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_RESET;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  // R1: pin reset or watchdog overflow lands in reset state
  a_r1_reset_entry: assert property (@(posedge clk) disable iff (rst)
    (!rst_pin_n || wdt_ovf) |=> (mode_q == MD_RESET));

  // R2: leaving reset gives high speed with no division
  a_r2_reset_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_RESET && rst_pin_n && !wdt_ovf) |=> (mode_q == MD_HIGH && sel_q == '0));

  // R3: applied exponent never exceeds the largest divisor
  a_r3_sel_range: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MD_RESET) |-> (sel_q <= SEL_MAX));

  // R4: no bus-cycle end, no divisor change
  a_r4_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (!bus_end && rst_pin_n && !wdt_ovf && mode_q != MD_RESET) |=> $stable(sel_q));

  // R10: standby ignores everything but an external interrupt
  a_r10_standby_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_STANDBY && !ext_irq && rst_pin_n && !wdt_ovf) |=> (mode_q == MD_STANDBY));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_pin_n,
  input  logic             wdt_ovf,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             stby_bit,
  input  logic             lowspd_bit,
  input  logic             wdt_src_bit,
  input  logic             sleep_req,
  input  logic             bus_end,
  input  logic             irq,
  input  logic             ext_irq,
  output logic [2:0]       mode,
  output logic             bm_clk_en,
  output logic             periph_clk_en
);

  logic             go_sleep;
  logic             go_standby;
  pcc_mode_e        mode_q;
  pcc_mode_e        mode_d;
  logic [SEL_W-1:0] sel_q;
  logic             restart;
  logic             run_next;
  logic             periph_q;

  pcc_sleep_decode u_dec (
    .sleep_req   (sleep_req),
    .stby_bit    (stby_bit),
    .lowspd_bit  (lowspd_bit),
    .wdt_src_bit (wdt_src_bit),
    .go_sleep    (go_sleep),
    .go_standby  (go_standby)
  );

  pcc_mode_fsm #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .rst_pin_n  (rst_pin_n),
    .wdt_ovf    (wdt_ovf),
    .clk_sel    (clk_sel),
    .bus_end    (bus_end),
    .go_sleep   (go_sleep),
    .go_standby (go_standby),
    .irq        (irq),
    .ext_irq    (ext_irq),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .sel_q      (sel_q),
    .restart    (restart)
  );

  assign run_next = mode_running(mode_d);

  pcc_clk_div #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run_next),
    .restart (restart),
    .sel     (sel_q),
    .bm_en_q (bm_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) periph_q <= 1'b0;
    else     periph_q <= (mode_d != MD_STANDBY) && (mode_d != MD_RESET);
  end

  assign periph_clk_en = periph_q;
  assign mode          = mode_q;

  // R7: bus masters halted whenever not running
  a_r7_bm_off_when_halted: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_SLEEP || mode_q == MD_STANDBY || mode_q == MD_RESET) |-> !bm_clk_en);

  // R8: standby stops the peripheral enable too
  a_r8_standby_periph_off: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_STANDBY) |-> !periph_clk_en);

  // R6: peripheral enable stays on in running and sleep modes
  a_r6_periph_on: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HIGH || mode_q == MD_MEDIUM || mode_q == MD_SLEEP) |-> periph_clk_en);

endmodule

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, rst_pin_n, wdt_ovf;
  logic [2:0] clk_sel;
  logic       stby_bit, lowspd_bit, wdt_src_bit;
  logic       sleep_req, bus_end, irq, ext_irq;
  logic [2:0] mode;
  logic       bm_clk_en, periph_clk_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_clk_ctrl dut_i (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf),
    .clk_sel(clk_sel), .stby_bit(stby_bit), .lowspd_bit(lowspd_bit),
    .wdt_src_bit(wdt_src_bit), .sleep_req(sleep_req), .bus_end(bus_end),
    .irq(irq), .ext_irq(ext_irq), .mode(mode), .bm_clk_en(bm_clk_en),
    .periph_clk_en(periph_clk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int div_of(input int sel);
    return 1 << ((sel > 5) ? 5 : sel);
  endfunction

  // after the restarting edge has just passed (index 0), check the pulse train
  task automatic check_train(input string req, input int d, input int ncyc);
    check({req, " idx0"}, bm_clk_en, 0);
    for (int k = 1; k <= ncyc; k++) begin
      step();
      check(req, bm_clk_en, (k % d == 0) ? 1 : 0);
    end
  endtask

  task automatic apply_sel(input int sel);
    int prev_mode;
    int d;
    d = div_of(sel);
    prev_mode = mode;
    clk_sel = 3'(sel);
    step(); step();
    check("R4 no change before bus end", mode, prev_mode);
    bus_end = 1'b1;
    step();
    bus_end = 1'b0;
    check("R4 mode after bus end", mode, (sel == 0) ? 1 : 2);
    check_train("R3 R5 divided pulse train", d, 2 * d + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; rst_pin_n = 1'b1; wdt_ovf = 1'b0; clk_sel = 3'd0;
    stby_bit = 1'b0; lowspd_bit = 1'b0; wdt_src_bit = 1'b0;
    sleep_req = 1'b0; bus_end = 1'b0; irq = 1'b0; ext_irq = 1'b0;
    @(negedge clk);
    step(); step();
    check("R1 reset mode", mode, 0);
    check("R1 reset bm", bm_clk_en, 0);
    check("R1 reset periph", periph_clk_en, 0);

    // R2: leave reset while the select field is non-zero
    clk_sel = 3'd3;
    rst = 1'b0;
    step();
    check("R2 mode high after reset", mode, 1);
    check("R6 periph on", periph_clk_en, 1);
    check_train("R2 undivided after reset", 1, 4);
    check("R4 select not applied yet", mode, 1);

    // R3/R4/R5: sweep all select codes
    for (int s = 0; s < 8; s++) apply_sel(s);
    apply_sel(0);

    // R7: light sleep from medium speed, R10 wake by irq
    apply_sel(2);
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R7 sleep mode", mode, 3);
    check("R6 periph in sleep", periph_clk_en, 1);
    for (int i = 0; i < 5; i++) begin
      step();
      check("R7 bm off in sleep", bm_clk_en, 0);
    end
    irq = 1'b1;
    step();
    irq = 1'b0;
    check("R10 wake to medium", mode, 2);
    check_train("R10 R5 train after wake", 4, 9);

    // R9: ignored strobes
    lowspd_bit = 1'b1;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R9 low-speed set ignored", mode, 2);
    lowspd_bit = 1'b0; stby_bit = 1'b1; wdt_src_bit = 1'b1;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R9 watchdog source set ignored", mode, 2);
    wdt_src_bit = 1'b0;

    // R8: standby, R10 irq ignored, ext_irq wakes
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R8 standby mode", mode, 4);
    check("R8 bm off", bm_clk_en, 0);
    check("R8 periph off", periph_clk_en, 0);
    irq = 1'b1;
    step();
    irq = 1'b0;
    check("R10 irq ignored in standby", mode, 4);
    check("R10 periph still off", periph_clk_en, 0);
    ext_irq = 1'b1;
    step();
    ext_irq = 1'b0;
    check("R10 ext wake to medium", mode, 2);
    check("R6 periph back on", periph_clk_en, 1);
    stby_bit = 1'b0;

    // R11: sleep wins over bus end, select not applied
    clk_sel = 3'd0;
    sleep_req = 1'b1;
    bus_end = 1'b1;
    step();
    sleep_req = 1'b0;
    bus_end = 1'b0;
    check("R11 sleep wins", mode, 3);
    ext_irq = 1'b1;
    step();
    ext_irq = 1'b0;
    check("R11 select not applied", mode, 2);
    check_train("R11 divisor kept", 4, 8);

    // R1: watchdog overflow from medium speed
    clk_sel = 3'd3;
    wdt_ovf = 1'b1;
    step();
    wdt_ovf = 1'b0;
    check("R1 wdt reset mode", mode, 0);
    check("R1 wdt reset bm", bm_clk_en, 0);
    check("R1 wdt reset periph", periph_clk_en, 0);
    step();
    check("R2 high after wdt reset", mode, 1);
    check_train("R2 undivided after wdt reset", 1, 3);

    // R1: reset pin while in standby
    stby_bit = 1'b1;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    check("R8 standby again", mode, 4);
    rst_pin_n = 1'b0;
    step();
    check("R1 pin reset from standby", mode, 0);
    step();
    check("R1 pin reset held", mode, 0);
    rst_pin_n = 1'b1;
    stby_bit = 1'b0;
    step();
    check("R2 high after pin reset", mode, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule